// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register memory command into a stream of single-word transfers. A command carries a base address, a register-select mask with one bit per architectural register, a kind (load multiple, store multiple, stack push, stack pop), one of four addressing modes and a writeback request. Once the command is accepted, the block spends one cycle working out the word count and the lowest address touched. It then offers one transfer per cycle on a valid/ready channel. Each transfer carries a word address, a register index and a load/store flag.

Registers always go out lowest index first, to ascending word addresses. The mode decides where that run of words sits relative to the base and what the base becomes afterwards. The push and pop kinds ignore the mode and writeback inputs. They take their base from the separate stack-pointer input, and they behave as decrement-before with writeback and increment-after with writeback respectively.

When the final transfer is accepted, the block raises a completion pulse in that same cycle, together with the post-command base value and a flag that says whether it is to be written back. The register file and the memory sit outside the block. Bases are assumed to be word aligned.

Top module: `lsm_addr_seq`

## Requirements
- R1: Transfers are issued in ascending register index, one for each set mask bit. Consecutive transfers of one command are exactly WORD_BYTES (4) apart in address.
- R2: Mode 0 (increment-after) starts at the base. Its post-command value is base + 4n, where n is the number of set mask bits.
- R3: Mode 1 (increment-before) starts at base + 4. Its post-command value is base + 4n, which is the last word accessed.
- R4: Mode 2 (decrement-after) ends with the last word at the base, so it starts at base − 4n + 4. Its post-command value is base − 4n.
- R5: Mode 3 (decrement-before) ends with the last word at base − 4, so it starts at base − 4n. Its post-command value is base − 4n.
- R6: With writeback off, wb_en stays low at completion and wb_value equals the unchanged base.
- R7: Kind 2 (push) stores at the stack-pointer input as decrement-before with writeback forced on. The mode and writeback inputs have no effect. Three words pushed from 0xBEE56848 give 0xBEE5683C.
- R8: Kind 3 (pop) loads from the stack-pointer input as increment-after with writeback forced on. The mode and writeback inputs have no effect.
- R9: An all-zero mask issues no transfer. It gives one completion pulse two cycles after acceptance, with wb_value equal to the base and wb_en equal to the writeback request.
- R10: While xfer_valid is high and xfer_ready is low, the address and the register index hold steady.
- R11: done pulses in the cycle in which the final transfer handshakes, alongside xfer_last. cmd_ready is low from acceptance until that completion.
- R12: xfer_load is high for kinds 0 (load multiple) and 3 (pop) and low for kinds 1 (store multiple) and 2 (push). Storing five registers increment-after with writeback from 0xBEDF5848 ends at 0xBEDF585C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command accepted this cycle if valid |
| cmd_kind | input | 2 | 0 load multiple, 1 store multiple, 2 push, 3 pop |
| cmd_mode | input | 2 | 0 inc-after, 1 inc-before, 2 dec-after, 3 dec-before |
| cmd_wb | input | 1 | Writeback requested (kinds 0 and 1) |
| cmd_base | input | ADDR_W | Base address (kinds 0 and 1) |
| cmd_sp | input | ADDR_W | Stack-pointer value (kinds 2 and 3) |
| cmd_mask | input | NREG | Register-select mask |
| xfer_valid | output | 1 | Transfer offered |
| xfer_ready | input | 1 | Transfer taken |
| xfer_addr | output | ADDR_W | Word address of transfer |
| xfer_reg | output | $clog2(NREG) | Register index of transfer |
| xfer_load | output | 1 | 1 load, 0 store |
| xfer_last | output | 1 | Final transfer of the command |
| done | output | 1 | Command completes this cycle |
| wb_en | output | 1 | Base is to be written back |
| wb_value | output | ADDR_W | Post-command base value |

## Verification
The checker watches the cycle-level rules on every clock. It checks the fixed address step and the rising register index between handshakes, the stability of a stalled offer, the busy command port and the single-cycle completion. It also checks that a command without writeback, or with an empty mask, reports its captured base unchanged. Only the bench's sweeps can show that each mode starts at the right address and finishes on the right base for every mask of a reduced register file. The same holds for push and pop ignoring the mode and writeback inputs, and for the two worked stack and store examples being reproduced.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

   typedef enum logic [1:0] {
      KIND_LDM  = 2'd0,
      KIND_STM  = 2'd1,
      KIND_PUSH = 2'd2,
      KIND_POP  = 2'd3
   } lsm_kind_e;

   typedef enum logic [1:0] {
      AM_INC_AFTER  = 2'd0,
      AM_INC_BEFORE = 2'd1,
      AM_DEC_AFTER  = 2'd2,
      AM_DEC_BEFORE = 2'd3
   } lsm_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CALC = 2'd1,
      ST_RUN  = 2'd2,
      ST_FIN  = 2'd3
   } lsm_state_e;

endpackage

// File: rtl/lsm_popcount.sv
module lsm_popcount #(
   parameter int N  = 16,
   parameter int CW = $clog2(N + 1)
) (
   input  logic [N-1:0]  vec,
   output logic [CW-1:0] count
);
   if (CW < $clog2(N + 1)) begin : g_bad_cw
      $error("lsm_popcount: CW too narrow");
   end

   logic [CW-1:0] partial [0:N];
   assign partial[0] = '0;

   for (genvar i = 0; i < N; i++) begin : g_acc
      assign partial[i+1] = partial[i] + CW'(vec[i]);
   end

   assign count = partial[N];
endmodule

// File: rtl/lsm_lowest_pick.sv
module lsm_lowest_pick #(
   parameter int N  = 16,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [N-1:0]  onehot,
   output logic [IW-1:0] index,
   output logic          only_one
);
   if (N < 2) begin : g_bad_n
      $error("lsm_lowest_pick: N must be at least 2");
   end

   logic [IW-1:0] acc [0:N];

   assign onehot   = vec & (~vec + N'(1));
   assign only_one = (vec != '0) && ((vec & ~onehot) == '0);
   assign acc[0]   = '0;

   for (genvar i = 0; i < N; i++) begin : g_enc
      assign acc[i+1] = acc[i] | ({IW{onehot[i]}} & IW'(i));
   end

   assign index = acc[N];
endmodule

// File: rtl/lsm_addr_calc.sv
module lsm_addr_calc
   import lsm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CW         = 5,
   parameter int WORD_BYTES = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [CW-1:0]     count,
   input  lsm_mode_e         mode,
   output logic [ADDR_W-1:0] first_addr,
   output logic [ADDR_W-1:0] final_base
);
   localparam int SH = $clog2(WORD_BYTES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   logic [ADDR_W-1:0] span;
   logic [ADDR_W-1:0] up_end;
   logic [ADDR_W-1:0] down_end;

   assign span     = ADDR_W'(count) << SH;
   assign up_end   = base + span;
   assign down_end = base - span;

   always_comb begin
      unique case (mode)
         AM_INC_AFTER: begin
            first_addr = base;
            final_base = up_end;
         end
         AM_INC_BEFORE: begin
            first_addr = base + STEP;
            final_base = up_end;
         end
         AM_DEC_AFTER: begin
            first_addr = down_end + STEP;
            final_base = down_end;
         end
         default: begin
            first_addr = down_end;
            final_base = down_end;
         end
      endcase
   end
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
   import lsm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4,
   localparam int IW        = $clog2(NREG),
   localparam int CW        = $clog2(NREG + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [1:0]        cmd_kind,
   input  logic [1:0]        cmd_mode,
   input  logic              cmd_wb,
   input  logic [ADDR_W-1:0] cmd_base,
   input  logic [ADDR_W-1:0] cmd_sp,
   input  logic [NREG-1:0]   cmd_mask,
   output logic              xfer_valid,
   input  logic              xfer_ready,
   output logic [ADDR_W-1:0] xfer_addr,
   output logic [IW-1:0]     xfer_reg,
   output logic              xfer_load,
   output logic              xfer_last,
   output logic              done,
   output logic              wb_en,
   output logic [ADDR_W-1:0] wb_value
);
   if (NREG < 2) begin : g_bad_nreg
      $error("lsm_addr_seq: NREG must be at least 2");
   end
   if (ADDR_W < 8) begin : g_bad_aw
      $error("lsm_addr_seq: ADDR_W must be at least 8");
   end
   if ((WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_wb
      $error("lsm_addr_seq: WORD_BYTES must be a power of two");
   end

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   lsm_state_e        state;
   logic [NREG-1:0]   rem_mask;
   logic [ADDR_W-1:0] cur_addr;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] wb_q_value;
   lsm_mode_e         mode_q;
   logic              wb_q;
   logic              load_q;

   logic [CW-1:0]     word_count;
   logic [NREG-1:0]   low_onehot;
   logic [IW-1:0]     low_index;
   logic              low_only;
   logic [ADDR_W-1:0] calc_first;
   logic [ADDR_W-1:0] calc_final;
   logic              cmd_fire;
   logic              xfer_fire;
   lsm_kind_e         kind_in;
   logic              stack_kind;

   lsm_popcount #(.N(NREG), .CW(CW)) u_count (
      .vec   (rem_mask),
      .count (word_count)
   );

   lsm_lowest_pick #(.N(NREG), .IW(IW)) u_pick (
      .vec      (rem_mask),
      .onehot   (low_onehot),
      .index    (low_index),
      .only_one (low_only)
   );

   lsm_addr_calc #(.ADDR_W(ADDR_W), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_calc (
      .base       (base_q),
      .count      (word_count),
      .mode       (mode_q),
      .first_addr (calc_first),
      .final_base (calc_final)
   );

   assign kind_in    = lsm_kind_e'(cmd_kind);
   assign stack_kind = (kind_in == KIND_PUSH) || (kind_in == KIND_POP);
   assign cmd_ready  = (state == ST_IDLE);
   assign cmd_fire   = cmd_valid && cmd_ready;
   assign xfer_valid = (state == ST_RUN);
   assign xfer_fire  = xfer_valid && xfer_ready;
   assign xfer_addr  = cur_addr;
   assign xfer_reg   = low_index;
   assign xfer_load  = load_q;
   assign xfer_last  = xfer_valid && low_only;
   assign done       = (xfer_fire && low_only) || (state == ST_FIN);
   assign wb_en      = done && wb_q;
   assign wb_value   = wb_q_value;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         rem_mask   <= '0;
         cur_addr   <= '0;
         base_q     <= '0;
         wb_q_value <= '0;
         mode_q     <= AM_INC_AFTER;
         wb_q       <= 1'b0;
         load_q     <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (cmd_fire) begin
                  rem_mask <= cmd_mask;
                  base_q   <= stack_kind ? cmd_sp : cmd_base;
                  load_q   <= (kind_in == KIND_LDM) || (kind_in == KIND_POP);
                  wb_q     <= stack_kind ? 1'b1 : cmd_wb;
                  case (kind_in)
                     KIND_PUSH: mode_q <= AM_DEC_BEFORE;
                     KIND_POP:  mode_q <= AM_INC_AFTER;
                     default:   mode_q <= lsm_mode_e'(cmd_mode);
                  endcase
                  state <= ST_CALC;
               end
            end
            ST_CALC: begin
               cur_addr   <= calc_first;
               wb_q_value <= wb_q ? calc_final : base_q;
               state      <= (word_count == '0) ? ST_FIN : ST_RUN;
            end
            ST_RUN: begin
               if (xfer_fire) begin
                  rem_mask <= rem_mask & ~low_onehot;
                  cur_addr <= cur_addr + STEP;
                  if (low_only) begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: begin
               state <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/lsm_addr_seq_chk.sv
module lsm_addr_seq_chk
   import lsm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int NREG       = 16,
   parameter int WORD_BYTES = 4,
   localparam int IW        = $clog2(NREG)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic [1:0]        cmd_kind,
   input logic              cmd_wb,
   input logic [ADDR_W-1:0] cmd_base,
   input logic [ADDR_W-1:0] cmd_sp,
   input logic [NREG-1:0]   cmd_mask,
   input logic              xfer_valid,
   input logic              xfer_ready,
   input logic [ADDR_W-1:0] xfer_addr,
   input logic [IW-1:0]     xfer_reg,
   input logic              xfer_last,
   input logic              done,
   input logic              wb_en,
   input logic [ADDR_W-1:0] wb_value
);
   logic [ADDR_W-1:0] cap_base;
   logic              cap_wb;
   logic              cap_empty;
   logic              stack_cmd;

   assign stack_cmd = (cmd_kind == KIND_PUSH) || (cmd_kind == KIND_POP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_base  <= '0;
         cap_wb    <= 1'b0;
         cap_empty <= 1'b0;
      end else if (cmd_valid && cmd_ready) begin
         cap_base  <= stack_cmd ? cmd_sp : cmd_base;
         cap_wb    <= stack_cmd || cmd_wb;
         cap_empty <= (cmd_mask == '0);
      end
   end

   p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_ready && !xfer_last)
      |=> (xfer_valid && xfer_addr == $past(xfer_addr) + ADDR_W'(WORD_BYTES)));

   p_reg_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_ready && !xfer_last) |=> (xfer_reg > $past(xfer_reg)));

   p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !xfer_ready)
      |=> (xfer_valid && $stable(xfer_addr) && $stable(xfer_reg)));

   p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_valid |-> !cmd_ready);

   p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_keep_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !cap_wb) |-> (!wb_en && wb_value == cap_base));

   p_empty_base_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && cap_empty) |-> (!xfer_valid && wb_value == cap_base && wb_en == cap_wb));
endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(
   .ADDR_W     (ADDR_W),
   .NREG       (NREG),
   .WORD_BYTES (WORD_BYTES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_ready  (cmd_ready),
   .cmd_kind   (cmd_kind),
   .cmd_wb     (cmd_wb),
   .cmd_base   (cmd_base),
   .cmd_sp     (cmd_sp),
   .cmd_mask   (cmd_mask),
   .xfer_valid (xfer_valid),
   .xfer_ready (xfer_ready),
   .xfer_addr  (xfer_addr),
   .xfer_reg   (xfer_reg),
   .xfer_last  (xfer_last),
   .done       (done),
   .wb_en      (wb_en),
   .wb_value   (wb_value)
);

// File: tb/lsm_addr_seq_test.sv
module lsm_addr_seq_test;
   localparam int AW = 32;
   localparam int NR = 6;
   localparam int IW = $clog2(NR);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [1:0]    cmd_kind = '0;
   logic [1:0]    cmd_mode = '0;
   logic          cmd_wb = 1'b0;
   logic [AW-1:0] cmd_base = '0;
   logic [AW-1:0] cmd_sp = '0;
   logic [NR-1:0] cmd_mask = '0;
   logic          xfer_valid;
   logic          xfer_ready = 1'b0;
   logic [AW-1:0] xfer_addr;
   logic [IW-1:0] xfer_reg;
   logic          xfer_load;
   logic          xfer_last;
   logic          done;
   logic          wb_en;
   logic [AW-1:0] wb_value;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   logic [15:0] lf = 16'hACE1;

   lsm_addr_seq #(.ADDR_W(AW), .NREG(NR), .WORD_BYTES(4)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_kind(cmd_kind), .cmd_mode(cmd_mode), .cmd_wb(cmd_wb),
      .cmd_base(cmd_base), .cmd_sp(cmd_sp), .cmd_mask(cmd_mask),
      .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
      .xfer_reg(xfer_reg), .xfer_load(xfer_load), .xfer_last(xfer_last),
      .done(done), .wb_en(wb_en), .wb_value(wb_value)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         errors = errors + 1;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   function automatic int nth_bit(input logic [NR-1:0] m, input int k);
      int seen = 0;
      for (int b = 0; b < NR; b++) begin
         if (m[b]) begin
            if (seen == k) return b;
            seen++;
         end
      end
      return -1;
   endfunction

   task automatic run_cmd(input logic [1:0] kind, input logic [1:0] mode,
                          input bit wb, input logic [AW-1:0] base,
                          input logic [AW-1:0] sp, input logic [NR-1:0] mask,
                          input bit stall, input string tag,
                          output logic [AW-1:0] got_wb);
      int n = 0;
      int k = 0;
      int guard = 0;
      bit fin = 0;
      bit held = 0;
      logic [AW-1:0] hold_addr = '0;
      logic [IW-1:0] hold_reg = '0;
      logic [1:0] em;
      bit ew;
      bit eload;
      logic [AW-1:0] eb, first, after, ewb;
      for (int b = 0; b < NR; b++) n += int'(mask[b]);
      case (kind)
         2'd2: begin em = 2'd3; ew = 1; eb = sp; end
         2'd3: begin em = 2'd0; ew = 1; eb = sp; end
         default: begin em = mode; ew = wb; eb = base; end
      endcase
      eload = (kind == 2'd0) || (kind == 2'd3);
      case (em)
         2'd0: begin first = eb;               after = eb + 4*n; end
         2'd1: begin first = eb + 4;           after = eb + 4*n; end
         2'd2: begin first = eb - 4*n + 4;     after = eb - 4*n; end
         default: begin first = eb - 4*n;      after = eb - 4*n; end
      endcase
      ewb = ew ? after : eb;
      got_wb = 'x;

      @(negedge clk);
      cmd_kind = kind; cmd_mode = mode; cmd_wb = wb; cmd_base = base;
      cmd_sp = sp; cmd_mask = mask; cmd_valid = 1'b1; xfer_ready = 1'b0;
      #1 chk(cmd_ready == 1'b1, {tag, " R11 idle ready"}, 32'(cmd_ready), 32'd1);
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!fin && guard < 60) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         xfer_ready = stall ? lf[0] : 1'b1;
         #2;
         if (xfer_valid) begin
            chk(!cmd_ready, {tag, " R11 busy"}, 32'(cmd_ready), 32'd0);
            if (n == 0) chk(0, {tag, " R9 transfer on empty mask"}, 32'd1, 32'd0);
            if (held) begin
               chk(xfer_addr == hold_addr, {tag, " R10 addr hold"}, xfer_addr, hold_addr);
               chk(xfer_reg == hold_reg, {tag, " R10 reg hold"}, 32'(xfer_reg), 32'(hold_reg));
            end
            if (xfer_ready) begin
               held = 0;
               chk(xfer_addr == first + 4*k, {tag, " R1-step/start addr (R2 R3 R4 R5)"},
                   xfer_addr, first + 4*k);
               chk(int'(xfer_reg) == nth_bit(mask, k), {tag, " R1 reg order"},
                   32'(xfer_reg), 32'(nth_bit(mask, k)));
               chk(xfer_load == eload, {tag, " R12 load flag"}, 32'(xfer_load), 32'(eload));
               chk(done == (k == n - 1), {tag, " R11 done timing"}, 32'(done), 32'(k == n - 1));
               chk(xfer_last == (k == n - 1), {tag, " R11 last flag"}, 32'(xfer_last),
                   32'(k == n - 1));
               if (k == n - 1) begin
                  chk(wb_en == ew, {tag, " R6 wb_en"}, 32'(wb_en), 32'(ew));
                  chk(wb_value == ewb, {tag, " R6 wb_value"}, wb_value, ewb);
                  got_wb = wb_value;
                  fin = 1;
               end
               k++;
            end else begin
               held = 1;
               hold_addr = xfer_addr;
               hold_reg = xfer_reg;
            end
         end else if (done) begin
            chk(n == 0 && guard == 1, {tag, " R9 empty completion timing"}, 32'(guard), 32'd1);
            chk(wb_en == ew, {tag, " R9 wb_en"}, 32'(wb_en), 32'(ew));
            chk(wb_value == eb, {tag, " R9 wb_value"}, wb_value, eb);
            got_wb = wb_value;
            fin = 1;
         end
         @(negedge clk);
         guard++;
      end
      xfer_ready = 1'b0;
      if (!fin) chk(0, {tag, " R11 completion missing"}, 32'(k), 32'(n));
   endtask

   initial begin
      logic [AW-1:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      chk(cmd_ready == 1'b1, "R11 reset ready", 32'(cmd_ready), 32'd1);
      chk(xfer_valid == 1'b0, "R11 reset no transfer", 32'(xfer_valid), 32'd0);
      chk(done == 1'b0, "R11 reset no done", 32'(done), 32'd0);

      run_cmd(2'd1, 2'd0, 1'b1, 32'hBEDF5848, 32'h0, 6'b111110, 1'b0, "R12 store5", r);
      chk(r == 32'hBEDF585C, "R12 store5 final", r, 32'hBEDF585C);
      run_cmd(2'd2, 2'd1, 1'b0, 32'h0, 32'hBEE56848, 6'b000111, 1'b1, "R7 push3", r);
      chk(r == 32'hBEE5683C, "R7 push3 final", r, 32'hBEE5683C);
      run_cmd(2'd3, 2'd2, 1'b0, 32'h0, 32'hBEE5683C, 6'b111000, 1'b0, "R8 pop3", r);
      chk(r == 32'hBEE56848, "R8 pop3 final", r, 32'hBEE56848);

      for (int kd = 0; kd < 4; kd++) begin
         for (int md = 0; md < 4; md++) begin
            for (int w = 0; w < 2; w++) begin
               for (int m = 0; m < 64; m++) begin
                  logic [AW-1:0] b;
                  b = (32'h1000_0000 + 32'(m) * 32'h0001_0104 + 32'(md) * 32'h40) & ~32'h3;
                  if (m == 5) b = 32'h0;
                  run_cmd(2'(kd), 2'(md), w[0], b, b ^ 32'h0F00_0000, 6'(m),
                          ((m + md) % 3) != 0, "sweep", r);
               end
            end
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule